// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

Two processors sharing a chip can use this block to send each other short messages and doorbell interrupts. Each of the two ports has a set of four outbound 16-bit mailboxes, written byte by byte. When a port writes the upper byte of one of its mailboxes, an interrupt source is raised for the other port. The other port reads the message through its inbound view. Reading the upper byte of that inbound mailbox retires the source and leaves the data as it was.

Each receiving port controls its own interrupt with three registers. The mask register has one bit per source and only the owning port can write it. The status register shows every pending source, masked or not. The cause register holds the unmasked view: a cause bit follows its pending source only while that source is unmasked, and keeps its last value while the source is masked. A port's interrupt output is active high whenever a pending source is unmasked.

An access is decoded only when the port's array enable (active low) is high and its register-space select (active low) is low. The 2-bit space field then picks one of three views: 0 is the port's own outbound mailboxes (read/write), 1 is the peer's mailboxes as seen by the receiver (read-only), and 2 is the control registers. Space 3 reads as zero. In the control space, index 0 is the mask (read/write through byte lane 0), index 1 is the cause register, index 2 is the status register, and index 3 reads as zero. Read data is registered. It is on the read data output after the clock edge that samples the read strobe, and it holds until the next read.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, all mailboxes, masks, pending sources and cause bits are zero, both interrupt outputs are low and both read data outputs read zero.
- R2: An access takes effect only when the port's mem_n input is 1 and its box_n input is 0. Any other combination ignores the strobes: no mailbox changes and no source is raised.
- R3: In space 0, a write updates lane 0 (bits 7:0) of the indexed own mailbox when be[0] is set and lane 1 (bits 15:8) when be[1] is set. A read returns the full 16-bit word on rdata after the edge that samples the read.
- R4: A space-0 write with be[1] set raises pending source idx at the peer on the write edge, and the peer's interrupt output is high after that edge if the source is unmasked. A write with only be[0] set raises nothing.
- R5: A port reading its own outbound mailbox (space 0, either lane) leaves the peer's pending sources unchanged.
- R6: A space-1 read with be[1] set clears the reader's pending source idx on that edge and returns the peer's mailbox idx unchanged. A space-1 read with only be[0] set returns the data and leaves the source pending.
- R7: A space-2 index-0 write with be[0] set loads bits 3:0 into the writer's own mask only, where bit k masks source k. The interrupt output is the OR over sources that are pending and unmasked, and it follows a mask change after that write edge.
- R8: Status (space 2, index 1 reads cause, index 2 reads status) bit k is 1 whenever source k is pending, regardless of the mask.
- R9: Cause bit k equals pending bit k one edge after source k is unmasked, updates on every edge while unmasked, and holds its value while source k is masked.
- R10: When a peer's upper-byte write and the receiver's upper-byte read target the same source in one cycle, the source stays pending (set wins).
- R11: Writes to space 1 and writes to cause or status (space 2, indices 1 and 2) have no effect on any mailbox, pending source or register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_mem_ni | input | 1 | Port A memory array enable, active low (must be 1 for register access) |
| a_box_ni | input | 1 | Port A register-space select, active low |
| a_space_i | input | 2 | Port A view: 0 own mailboxes, 1 inbound mailboxes, 2 control |
| a_idx_i | input | 2 | Port A mailbox or register index |
| a_be_i | input | 2 | Port A byte enables, bit 1 is the upper byte |
| a_wr_i | input | 1 | Port A write strobe |
| a_rd_i | input | 1 | Port A read strobe |
| a_wdata_i | input | 16 | Port A write data |
| a_rdata_o | output | 16 | Port A registered read data |
| a_irq_o | output | 1 | Port A interrupt, active high |
| b_mem_ni | input | 1 | Port B memory array enable, active low |
| b_box_ni | input | 1 | Port B register-space select, active low |
| b_space_i | input | 2 | Port B view |
| b_idx_i | input | 2 | Port B mailbox or register index |
| b_be_i | input | 2 | Port B byte enables |
| b_wr_i | input | 1 | Port B write strobe |
| b_rd_i | input | 1 | Port B read strobe |
| b_wdata_i | input | 16 | Port B write data |
| b_rdata_o | output | 16 | Port B registered read data |
| b_irq_o | output | 1 | Port B interrupt, active high |

## Verification
Mailbox contents, pending sources, masks and the interrupt outputs all change on the edge that samples a write or clearing read. The bench drives each operation one time unit after an edge and checks the interrupt lines one time unit after the next edge. Read data takes a single register stage, so every read check samples rdata just after the edge that captured the strobe. A cause bit picks up an unmask only one edge after the mask write, because it uses the registered mask. For that reason the bench puts one idle cycle between the unmask and the cause read.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    SP_OWN = 2'd0,
    SP_IN  = 2'd1,
    SP_CTL = 2'd2,
    SP_RSV = 2'd3
  } space_e;

  localparam int CTL_MASK   = 0;
  localparam int CTL_CAUSE  = 1;
  localparam int CTL_STATUS = 2;
endpackage

// File: rtl/mbox_bank.sv
module mbox_bank #(
  parameter int NUM_MBOX = 4,
  parameter int DW       = 16,
  localparam int IW      = $clog2(NUM_MBOX),
  localparam int NB      = DW / 8
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               we_i,
  input  logic [IW-1:0]                      idx_i,
  input  logic [NB-1:0]                      be_i,
  input  logic [DW-1:0]                      wd_i,
  output logic [NUM_MBOX-1:0][DW-1:0]        mb_o,
  output logic [NUM_MBOX-1:0]                set_o
);
  logic [NUM_MBOX-1:0][DW-1:0] mb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mb_q <= '0;
    end else if (we_i) begin
      for (int k = 0; k < NUM_MBOX; k++) begin
        for (int b = 0; b < NB; b++) begin
          if (idx_i == IW'(k) && be_i[b]) mb_q[k][b*8 +: 8] <= wd_i[b*8 +: 8];
        end
      end
    end
  end

  // only the top lane rings the doorbell
  for (genvar k = 0; k < NUM_MBOX; k++) begin : g_set
    assign set_o[k] = we_i && be_i[NB-1] && (idx_i == IW'(k));
  end

  assign mb_o = mb_q;
endmodule

// File: rtl/mbox_irq_ctl.sv
module mbox_irq_ctl #(
  parameter int NUM_MBOX = 4,
  localparam int IW      = $clog2(NUM_MBOX)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_MBOX-1:0] set_i,
  input  logic                clr_en_i,
  input  logic [IW-1:0]       clr_idx_i,
  input  logic                mask_we_i,
  input  logic [NUM_MBOX-1:0] mask_wd_i,
  output logic [NUM_MBOX-1:0] pend_o,
  output logic [NUM_MBOX-1:0] mask_o,
  output logic [NUM_MBOX-1:0] cause_o,
  output logic                irq_o
);
  logic [NUM_MBOX-1:0] pend_q, mask_q, cause_q;
  logic [NUM_MBOX-1:0] clr_vec, pend_d, cause_d;

  always_comb begin
    clr_vec = '0;
    if (clr_en_i) clr_vec[clr_idx_i] = 1'b1;
    pend_d  = (pend_q & ~clr_vec) | set_i;           // set wins
    cause_d = (cause_q & mask_q) | (pend_d & ~mask_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      mask_q  <= '0;
      cause_q <= '0;
    end else begin
      pend_q  <= pend_d;
      cause_q <= cause_d;
      if (mask_we_i) mask_q <= mask_wd_i;
    end
  end

  assign pend_o  = pend_q;
  assign mask_o  = mask_q;
  assign cause_o = cause_q;
  assign irq_o   = |(pend_q & ~mask_q);
endmodule

// File: rtl/mbox_rdport.sv
module mbox_rdport
  import mbox_pkg::*;
#(
  parameter int NUM_MBOX = 4,
  parameter int DW       = 16,
  localparam int IW      = $clog2(NUM_MBOX)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        rd_i,
  input  logic [1:0]                  space_i,
  input  logic [IW-1:0]               idx_i,
  input  logic [NUM_MBOX-1:0][DW-1:0] own_i,
  input  logic [NUM_MBOX-1:0][DW-1:0] peer_i,
  input  logic [NUM_MBOX-1:0]         mask_i,
  input  logic [NUM_MBOX-1:0]         cause_i,
  input  logic [NUM_MBOX-1:0]         pend_i,
  output logic [DW-1:0]               rdata_o
);
  logic [DW-1:0] rsel, rdata_q;

  always_comb begin
    rsel = '0;
    case (space_i)
      SP_OWN:  rsel = own_i[idx_i];
      SP_IN:   rsel = peer_i[idx_i];
      SP_CTL: begin
        if (idx_i == IW'(CTL_MASK))        rsel = DW'(mask_i);
        else if (idx_i == IW'(CTL_CAUSE))  rsel = DW'(cause_i);
        else if (idx_i == IW'(CTL_STATUS)) rsel = DW'(pend_i);
      end
      default: rsel = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rsel;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
  import mbox_pkg::*;
#(
  parameter int NUM_MBOX = 4,
  parameter int DW       = 16,
  localparam int IW      = $clog2(NUM_MBOX),
  localparam int NB      = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_mem_ni,
  input  logic          a_box_ni,
  input  logic [1:0]    a_space_i,
  input  logic [IW-1:0] a_idx_i,
  input  logic [NB-1:0] a_be_i,
  input  logic          a_wr_i,
  input  logic          a_rd_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic [DW-1:0] a_rdata_o,
  output logic          a_irq_o,
  input  logic          b_mem_ni,
  input  logic          b_box_ni,
  input  logic [1:0]    b_space_i,
  input  logic [IW-1:0] b_idx_i,
  input  logic [NB-1:0] b_be_i,
  input  logic          b_wr_i,
  input  logic          b_rd_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic [DW-1:0] b_rdata_o,
  output logic          b_irq_o
);
  localparam int NP = 2;

  logic [NP-1:0]                        acc, wr_s, rd_s, wr_up, clr_en, mask_we, irq;
  logic [NP-1:0][1:0]                   space;
  logic [NP-1:0][IW-1:0]                idx;
  logic [NP-1:0][NB-1:0]                be;
  logic [NP-1:0][DW-1:0]                wd, rdata;
  logic [NP-1:0][NUM_MBOX-1:0][DW-1:0]  mb;
  logic [NP-1:0][NUM_MBOX-1:0]          set, pend, mask, cause;

  assign acc   = {b_mem_ni & ~b_box_ni, a_mem_ni & ~a_box_ni};
  assign wr_s  = acc & {b_wr_i, a_wr_i};
  assign rd_s  = acc & {b_rd_i, a_rd_i};
  assign space = {b_space_i, a_space_i};
  assign idx   = {b_idx_i, a_idx_i};
  assign be    = {b_be_i, a_be_i};
  assign wd    = {b_wdata_i, a_wdata_i};

  for (genvar p = 0; p < NP; p++) begin : g_port
    localparam int PEER = NP - 1 - p;

    assign wr_up[p]   = wr_s[p] && (space[p] == SP_OWN) && be[p][NB-1];
    assign clr_en[p]  = rd_s[p] && (space[p] == SP_IN) && be[p][NB-1];
    assign mask_we[p] = wr_s[p] && (space[p] == SP_CTL) &&
                        (idx[p] == IW'(CTL_MASK)) && be[p][0];

    mbox_bank #(.NUM_MBOX(NUM_MBOX), .DW(DW)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_s[p] && (space[p] == SP_OWN)),
      .idx_i  (idx[p]),
      .be_i   (be[p]),
      .wd_i   (wd[p]),
      .mb_o   (mb[p]),
      .set_o  (set[p])
    );

    // receiver side: sources come from the peer's bank
    mbox_irq_ctl #(.NUM_MBOX(NUM_MBOX)) u_ctl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (set[PEER]),
      .clr_en_i  (clr_en[p]),
      .clr_idx_i (idx[p]),
      .mask_we_i (mask_we[p]),
      .mask_wd_i (wd[p][NUM_MBOX-1:0]),
      .pend_o    (pend[p]),
      .mask_o    (mask[p]),
      .cause_o   (cause[p]),
      .irq_o     (irq[p])
    );

    mbox_rdport #(.NUM_MBOX(NUM_MBOX), .DW(DW)) u_rd (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rd_i    (rd_s[p]),
      .space_i (space[p]),
      .idx_i   (idx[p]),
      .own_i   (mb[p]),
      .peer_i  (mb[PEER]),
      .mask_i  (mask[p]),
      .cause_i (cause[p]),
      .pend_i  (pend[p]),
      .rdata_o (rdata[p])
    );
  end

  assign a_rdata_o = rdata[0];
  assign b_rdata_o = rdata[1];
  assign a_irq_o   = irq[0];
  assign b_irq_o   = irq[1];
endmodule

// File: rtl/mbox_irq_ctrl_chk.sv
module mbox_irq_ctrl_chk #(
  parameter int NUM_MBOX = 4,
  localparam int IW      = $clog2(NUM_MBOX)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [1:0]                 wr_up,
  input logic [1:0]                 clr_en,
  input logic [1:0][IW-1:0]         idx,
  input logic [1:0][NUM_MBOX-1:0]   pend,
  input logic [1:0][NUM_MBOX-1:0]   mask,
  input logic [1:0][NUM_MBOX-1:0]   cause,
  input logic [1:0]                 irq
);
  always_comb begin
    if (!rst_ni) a_r1_irq_low_in_reset: assert (irq == 2'b00);
  end

  for (genvar r = 0; r < 2; r++) begin : g_rx
    localparam int W = 1 - r;

    a_r4_upper_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_up[W] |=> pend[r][$past(idx[W])]);

    a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_en[r] && !(wr_up[W] && idx[W] == idx[r])) |=> !pend[r][$past(idx[r])]);

    a_r5_pend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_up[W] && !clr_en[r]) |=> $stable(pend[r]));

    a_r7_all_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&mask[r]) |-> !irq[r]);

    a_r9_masked_cause_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_ni |=> (((cause[r] ^ $past(cause[r])) & $past(mask[r])) == '0));

    a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_up[W] && clr_en[r] && idx[W] == idx[r]) |=> pend[r][$past(idx[r])]);
  end
endmodule

bind mbox_irq_ctrl mbox_irq_ctrl_chk #(.NUM_MBOX(NUM_MBOX)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_up  (wr_up),
  .clr_en (clr_en),
  .idx    (idx),
  .pend   (pend),
  .mask   (mask),
  .cause  (cause),
  .irq    (irq)
);

// File: tb/mbox_irq_ctrl_bench.sv
module mbox_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        a_mem_n, a_box_n, a_wr, a_rd, a_irq;
  logic        b_mem_n, b_box_n, b_wr, b_rd, b_irq;
  logic [1:0]  a_sp, a_idx, a_be, b_sp, b_idx, b_be;
  logic [15:0] a_wd, a_rdat, b_wd, b_rdat;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_irq_ctrl u_mbox_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .a_mem_ni(a_mem_n), .a_box_ni(a_box_n), .a_space_i(a_sp), .a_idx_i(a_idx),
    .a_be_i(a_be), .a_wr_i(a_wr), .a_rd_i(a_rd), .a_wdata_i(a_wd),
    .a_rdata_o(a_rdat), .a_irq_o(a_irq),
    .b_mem_ni(b_mem_n), .b_box_ni(b_box_n), .b_space_i(b_sp), .b_idx_i(b_idx),
    .b_be_i(b_be), .b_wr_i(b_wr), .b_rd_i(b_rd), .b_wdata_i(b_wd),
    .b_rdata_o(b_rdat), .b_irq_o(b_irq)
  );

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    {a_mem_n, a_box_n, a_wr, a_rd} = 4'b0100;
    {b_mem_n, b_box_n, b_wr, b_rd} = 4'b0100;
    a_sp = 0; a_idx = 0; a_be = 0; a_wd = 0;
    b_sp = 0; b_idx = 0; b_be = 0; b_wd = 0;
  endtask

  task automatic drv(input bit p, input logic mn, input logic bn, input logic [1:0] sp,
                     input logic [1:0] ix, input logic [1:0] be, input logic wr,
                     input logic rd, input logic [15:0] wd);
    if (!p) begin
      a_mem_n = mn; a_box_n = bn; a_sp = sp; a_idx = ix; a_be = be; a_wr = wr; a_rd = rd; a_wd = wd;
    end else begin
      b_mem_n = mn; b_box_n = bn; b_sp = sp; b_idx = ix; b_be = be; b_wr = wr; b_rd = rd; b_wd = wd;
    end
  endtask

  task automatic wr_op(input bit p, input logic [1:0] sp, input logic [1:0] ix,
                       input logic [1:0] be, input logic [15:0] wd);
    drv(p, 1'b1, 1'b0, sp, ix, be, 1'b1, 1'b0, wd);
    step();
    idle();
  endtask

  task automatic rd_chk(input bit p, input logic [1:0] sp, input logic [1:0] ix,
                        input logic [1:0] be, input logic [15:0] exp, input string tag);
    drv(p, 1'b1, 1'b0, sp, ix, be, 1'b0, 1'b1, 16'h0);
    step();
    chk((p ? b_rdat : a_rdat) === exp, tag, p ? b_rdat : a_rdat, exp);
    idle();
  endtask

  task automatic irq_chk(input bit p, input logic exp, input string tag);
    chk((p ? b_irq : a_irq) === exp, tag, {15'd0, p ? b_irq : a_irq}, {15'd0, exp});
  endtask

  task automatic t_reset();
    chk(a_irq === 1'b0 && b_irq === 1'b0, "R1 irq in reset", {14'd0, a_irq, b_irq}, 16'h0);
    chk(a_rdat === 16'h0 && b_rdat === 16'h0, "R1 rdata in reset", a_rdat | b_rdat, 16'h0);
    step();
    rst_ni = 1'b1;
    step();
    rd_chk(0, 2'd2, 2'd0, 2'b01, 16'h0, "R1 mask A");
    rd_chk(1, 2'd2, 2'd2, 2'b01, 16'h0, "R1 status B");
    rd_chk(0, 2'd0, 2'd3, 2'b11, 16'h0, "R1 mailbox A3");
  endtask

  task automatic t_bytes();
    wr_op(0, 2'd0, 2'd1, 2'b01, 16'hFF34);
    irq_chk(1, 1'b0, "R4 lower-only no irq");
    rd_chk(1, 2'd2, 2'd2, 2'b01, 16'h0, "R4 lower-only status");
    rd_chk(0, 2'd0, 2'd1, 2'b11, 16'h0034, "R3 lower lane");
    wr_op(0, 2'd0, 2'd1, 2'b10, 16'hAB99);
    irq_chk(1, 1'b1, "R4 upper write irq");
    irq_chk(0, 1'b0, "R4 writer irq stays low");
    rd_chk(1, 2'd2, 2'd2, 2'b01, 16'h0002, "R4 status source 1");
    rd_chk(0, 2'd0, 2'd1, 2'b11, 16'hAB34, "R3 merged word");
    rd_chk(0, 2'd0, 2'd1, 2'b10, 16'hAB34, "R5 own readback");
    rd_chk(1, 2'd2, 2'd2, 2'b01, 16'h0002, "R5 status after readback");
    irq_chk(1, 1'b1, "R5 irq after readback");
  endtask

  task automatic t_clear();
    rd_chk(1, 2'd1, 2'd1, 2'b01, 16'hAB34, "R6 lower read data");
    irq_chk(1, 1'b1, "R6 lower read keeps irq");
    rd_chk(1, 2'd1, 2'd1, 2'b10, 16'hAB34, "R6 upper read data");
    irq_chk(1, 1'b0, "R6 upper read clears irq");
    rd_chk(1, 2'd2, 2'd2, 2'b01, 16'h0, "R6 status cleared");
    rd_chk(1, 2'd1, 2'd1, 2'b11, 16'hAB34, "R6 data unchanged");
  endtask

  task automatic t_gate();
    drv(0, 1'b0, 1'b0, 2'd0, 2'd2, 2'b11, 1'b1, 1'b0, 16'h1234);
    step(); idle();
    drv(0, 1'b1, 1'b1, 2'd0, 2'd2, 2'b11, 1'b1, 1'b0, 16'h5678);
    step(); idle();
    irq_chk(1, 1'b0, "R2 gated writes no irq");
    rd_chk(0, 2'd0, 2'd2, 2'b11, 16'h0, "R2 gated writes no data");
    drv(0, 1'b0, 1'b0, 2'd0, 2'd2, 2'b11, 1'b0, 1'b1, 16'h0);
    step(); idle();
    chk(a_rdat === 16'h0, "R2 gated read holds rdata", a_rdat, 16'h0);
  endtask

  task automatic t_mask();
    wr_op(1, 2'd2, 2'd0, 2'b01, 16'h0001);
    rd_chk(0, 2'd2, 2'd0, 2'b01, 16'h0, "R7 peer mask untouched");
    rd_chk(1, 2'd2, 2'd0, 2'b01, 16'h0001, "R7 own mask");
    wr_op(0, 2'd0, 2'd0, 2'b10, 16'h5500);
    irq_chk(1, 1'b0, "R7 masked source quiet");
    rd_chk(1, 2'd2, 2'd2, 2'b01, 16'h0001, "R8 masked status");
    rd_chk(1, 2'd2, 2'd1, 2'b01, 16'h0, "R9 masked cause held");
    wr_op(1, 2'd2, 2'd0, 2'b01, 16'h0000);
    irq_chk(1, 1'b1, "R7 unmask raises irq");
    step();
    rd_chk(1, 2'd2, 2'd1, 2'b01, 16'h0001, "R9 cause after unmask");
    wr_op(0, 2'd0, 2'd2, 2'b10, 16'h7700);
    rd_chk(1, 2'd2, 2'd2, 2'b01, 16'h0005, "R8 two sources");
    rd_chk(1, 2'd1, 2'd0, 2'b10, 16'h5500, "R6 clear source 0");
    rd_chk(1, 2'd2, 2'd1, 2'b01, 16'h0004, "R9 cause tracks clear");
    rd_chk(1, 2'd1, 2'd2, 2'b10, 16'h7700, "R6 clear source 2");
    irq_chk(1, 1'b0, "R6 all cleared");
    wr_op(0, 2'd2, 2'd0, 2'b01, 16'h000F);
    wr_op(1, 2'd0, 2'd3, 2'b10, 16'hC000);
    irq_chk(0, 1'b0, "R7 full mask quiet");
    rd_chk(0, 2'd2, 2'd2, 2'b01, 16'h0008, "R8 status under full mask");
    wr_op(0, 2'd2, 2'd0, 2'b01, 16'h0000);
    irq_chk(0, 1'b1, "R7 full unmask irq");
    rd_chk(0, 2'd1, 2'd3, 2'b10, 16'hC000, "R6 port A clear");
    irq_chk(0, 1'b0, "R6 port A irq low");
  endtask

  task automatic t_collide();
    wr_op(0, 2'd0, 2'd2, 2'b10, 16'h1100);
    drv(0, 1'b1, 1'b0, 2'd0, 2'd2, 2'b10, 1'b1, 1'b0, 16'h2200);
    drv(1, 1'b1, 1'b0, 2'd1, 2'd2, 2'b10, 1'b0, 1'b1, 16'h0);
    step(); idle();
    irq_chk(1, 1'b1, "R10 set wins irq");
    rd_chk(1, 2'd2, 2'd2, 2'b01, 16'h0004, "R10 set wins status");
    rd_chk(1, 2'd1, 2'd2, 2'b10, 16'h2200, "R10 later clear");
    irq_chk(1, 1'b0, "R10 cleared after");
  endtask

  task automatic t_ignored();
    wr_op(1, 2'd1, 2'd0, 2'b11, 16'hFFFF);
    rd_chk(0, 2'd0, 2'd0, 2'b11, 16'h5500, "R11 inbound write ignored");
    irq_chk(0, 1'b0, "R11 no irq A");
    irq_chk(1, 1'b0, "R11 no irq B");
    wr_op(1, 2'd2, 2'd1, 2'b11, 16'hFFFF);
    wr_op(1, 2'd2, 2'd2, 2'b11, 16'hFFFF);
    rd_chk(1, 2'd2, 2'd1, 2'b01, 16'h0, "R11 cause not writable");
    rd_chk(1, 2'd2, 2'd2, 2'b01, 16'h0, "R11 status not writable");
    rd_chk(1, 2'd2, 2'd0, 2'b01, 16'h0, "R11 mask untouched");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    idle();
    #1;
    t_reset();
    t_bytes();
    t_clear();
    t_gate();
    t_mask();
    t_collide();
    t_ignored();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule